// File: doc/BRIEF.md
# Condition-Preserving Integer Execute Stage

This block is the arithmetic end of a small processor pipeline. It takes one operation per cycle (an opcode, two data operands and a per-operation condition-write enable) and returns a registered result one clock later, along with a strobe that marks the cycle as carrying a register result. A single condition bit lives inside the stage. Only two operations may write it: the ordinary add, which reports whether its sum is zero, and the equality compare, which reports whether its operands match. Both write it only when the enable is asserted.

Every other operation leaves the condition bit alone. This includes the address-style add, register moves, constant loads and load or store data passing through. As a result, a compiler can put pointer arithmetic and memory traffic between a compare and the instructions that use its outcome. Two operations use the bit. A conditional select chooses between its operands based on the bit, and a set-on-condition operation turns the bit into a 0 or 1 word. Both see the bit as it stood before the clock edge that retires them.

Top module: `alu_flag_exec`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `cond_flag` is 0, `res_valid` is 0 and `res_data` is 0.
- R2: An accepted opcode 0 (ordinary add) drives `res_data` to (a + b) mod 2^16 with `res_valid` high on the next cycle. When `in_flag_we` is 1, `cond_flag` becomes 1 if that sum is zero and 0 otherwise.
- R3: Opcode 0 with `in_flag_we` at 0 still produces its sum but leaves `cond_flag` unchanged.
- R4: Opcode 1 (address-style add) produces the same wrapped sum as opcode 0 and never changes `cond_flag`, whatever the value of `in_flag_we`.
- R5: Opcode 2 (equality compare) with `in_flag_we` at 1 sets `cond_flag` to 1 when all 16 bits of a and b match and to 0 otherwise. It never raises `res_valid`, and `res_data` keeps its previous value. With `in_flag_we` at 0 it changes nothing.
- R6: Opcode 3 (select) returns a when `cond_flag` is 1 and b when it is 0, with `res_valid` high on the next cycle.
- R7: Opcode 4 (set-on-condition) returns 16'h0001 when `cond_flag` is 1 and 16'h0000 when it is 0, with `res_valid` high on the next cycle.
- R8: Opcode 5 (move, constant or memory data pass-through) returns a with `res_valid` high on the next cycle and never changes `cond_flag`.
- R9: A cycle with `in_valid` at 0 gives `res_valid` 0 on the next cycle and leaves `res_data` and `cond_flag` unchanged.
- R10: Opcodes 6 and 7 behave like an idle cycle: no result, `res_data` held, `cond_flag` unchanged even with `in_flag_we` at 1.
- R11: The condition update and the result write happen on the same edge. A select or set-on-condition issued in the cycle right after a condition-writing operation sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 3 | Opcode (0 add, 1 address add, 2 compare, 3 select, 4 set-on-condition, 5 pass) |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| in_flag_we | input | 1 | Allows this operation to write the condition bit |
| res_data | output | 16 | Registered result |
| res_valid | output | 1 | `res_data` was written on the last edge |
| cond_flag | output | 1 | Current condition bit |

## Verification
The properties assume that reset is released synchronously to the clock and that the opcode, operands and enable are defined (not X) whenever `in_valid` is high. The sum and select checks compare against their own values from the previous cycle, so they depend on the inputs being stable at the edge. The bench changes every input only on the falling edge and runs each operation, including the reserved opcodes and the idle case, with the enable both high and low. This keeps all stimulus inside those assumptions while still reaching each path that could disturb the condition bit.

// File: rtl/alu_fp_pkg.sv
package alu_fp_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 3'd0,
      OP_ADDX  = 3'd1,
      OP_CMPEQ = 3'd2,
      OP_SEL   = 3'd3,
      OP_SETC  = 3'd4,
      OP_PASS  = 3'd5
   } alu_op_e;

   localparam int ADDER_BEHAV = 0;
   localparam int ADDER_CSEL  = 1;

endpackage

// File: rtl/alu_fp_adder.sv
module alu_fp_adder #(
   parameter int DATA_W = 16,
   parameter int ARCH   = 0,
   parameter int BLK_W  = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] sum_o
);
   import alu_fp_pkg::*;

   localparam int NBLK = (BLK_W > 0) ? (DATA_W / BLK_W) : 1;

   generate
      if (BLK_W < 1) begin : g_bad_blk
         $error("alu_fp_adder: BLK_W must be at least 1");
      end
      if (ARCH != ADDER_BEHAV && ARCH != ADDER_CSEL) begin : g_bad_arch
         $error("alu_fp_adder: unknown ARCH");
      end

      if (ARCH == ADDER_CSEL) begin : g_csel
         if (BLK_W < 1 || (DATA_W % BLK_W) != 0) begin : g_bad_split
            $error("alu_fp_adder: DATA_W must be a multiple of BLK_W");
         end
         logic [NBLK-1:0] cy;
         assign cy[0] = 1'b0;
         for (genvar k = 0; k < NBLK; k++) begin : g_blk
            if (k < NBLK - 1) begin : g_mid
               logic [BLK_W:0] s0;
               logic [BLK_W:0] s1;
               assign s0 = {1'b0, a_i[k*BLK_W +: BLK_W]} + {1'b0, b_i[k*BLK_W +: BLK_W]};
               assign s1 = s0 + {{BLK_W{1'b0}}, 1'b1};
               assign sum_o[k*BLK_W +: BLK_W] = cy[k] ? s1[BLK_W-1:0] : s0[BLK_W-1:0];
               assign cy[k+1] = cy[k] ? s1[BLK_W] : s0[BLK_W];
            end else begin : g_top
               logic [BLK_W-1:0] s0;
               logic [BLK_W-1:0] s1;
               assign s0 = a_i[k*BLK_W +: BLK_W] + b_i[k*BLK_W +: BLK_W];
               assign s1 = s0 + {{(BLK_W-1){1'b0}}, 1'b1};
               assign sum_o[k*BLK_W +: BLK_W] = cy[k] ? s1 : s0;
            end
         end
      end else begin : g_behav
         assign sum_o = a_i + b_i;
      end
   endgenerate

endmodule

// File: rtl/alu_fp_flagreg.sv
module alu_fp_flagreg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en_i,
   input  logic d_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= 1'b0;
      else if (wr_en_i) q_o <= d_i;
   end
endmodule

// File: rtl/alu_fp_resreg.sv
module alu_fp_resreg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o,
   output logic              vld_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o   <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= we_i;
         if (we_i) q_o <= d_i;
      end
   end
endmodule

// File: rtl/alu_flag_exec.sv
module alu_flag_exec #(
   parameter int DATA_W     = 16,
   parameter int ADDER_ARCH = 1,
   parameter int CSEL_BLK   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic              in_flag_we,
   output logic [DATA_W-1:0] res_data,
   output logic              res_valid,
   output logic              cond_flag
);
   import alu_fp_pkg::*;

   localparam logic [DATA_W-1:0] ONE_W = {{(DATA_W-1){1'b0}}, 1'b1};

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("alu_flag_exec: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] sum;
   logic              sum_zero;
   logic              ops_equal;
   logic              flag_wr;
   logic              flag_d;
   logic              res_we;
   logic [DATA_W-1:0] res_d;

   alu_fp_adder #(
      .DATA_W (DATA_W),
      .ARCH   (ADDER_ARCH),
      .BLK_W  (CSEL_BLK)
   ) u_add (
      .a_i   (in_a),
      .b_i   (in_b),
      .sum_o (sum)
   );

   assign sum_zero  = ~|sum;
   assign ops_equal = ~|(in_a ^ in_b);

   always_comb begin
      flag_wr = 1'b0;
      flag_d  = cond_flag;
      res_we  = 1'b0;
      res_d   = '0;
      if (in_valid) begin
         case (alu_op_e'(in_op))
            OP_ADD: begin
               res_we  = 1'b1;
               res_d   = sum;
               flag_wr = in_flag_we;
               flag_d  = sum_zero;
            end
            OP_ADDX: begin
               res_we = 1'b1;
               res_d  = sum;
            end
            OP_CMPEQ: begin
               flag_wr = in_flag_we;
               flag_d  = ops_equal;
            end
            OP_SEL: begin
               res_we = 1'b1;
               res_d  = cond_flag ? in_a : in_b;
            end
            OP_SETC: begin
               res_we = 1'b1;
               res_d  = cond_flag ? ONE_W : '0;
            end
            OP_PASS: begin
               res_we = 1'b1;
               res_d  = in_a;
            end
            default: begin
               res_we = 1'b0;
            end
         endcase
      end
   end

   alu_fp_flagreg u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (flag_wr),
      .d_i     (flag_d),
      .q_o     (cond_flag)
   );

   alu_fp_resreg #(
      .DATA_W (DATA_W)
   ) u_res (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (res_we),
      .d_i   (res_d),
      .q_o   (res_data),
      .vld_o (res_valid)
   );

endmodule

// File: rtl/alu_flag_exec_chk.sv
module alu_flag_exec_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        in_op,
   input logic [DATA_W-1:0] in_a,
   input logic [DATA_W-1:0] in_b,
   input logic              in_flag_we,
   input logic [DATA_W-1:0] res_data,
   input logic              res_valid,
   input logic              cond_flag
);
   import alu_fp_pkg::*;

   logic writer;
   assign writer = in_valid && in_flag_we && (in_op == OP_ADD || in_op == OP_CMPEQ);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (!cond_flag && !res_valid && res_data == '0); // R1
      end
   end

   AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_op == OP_ADD || in_op == OP_ADDX)
      |=> res_valid && res_data == DATA_W'($past(in_a) + $past(in_b))); // R2

   AST_ADD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_flag_we && in_op == OP_ADD
      |=> cond_flag == (DATA_W'($past(in_a) + $past(in_b)) == '0)); // R2

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !writer |=> $stable(cond_flag)); // R4

   AST_CMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_flag_we && in_op == OP_CMPEQ
      |=> cond_flag == ($past(in_a) == $past(in_b))); // R5

   AST_CMP_NORES: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == OP_CMPEQ |=> !res_valid && $stable(res_data)); // R5

   AST_SEL_PICK: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == OP_SEL
      |=> res_valid && res_data == ($past(cond_flag) ? $past(in_a) : $past(in_b))); // R6

   AST_SETC_VAL: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == OP_SETC
      |=> res_valid && res_data == DATA_W'($past(cond_flag))); // R7

   AST_PASS_VAL: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == OP_PASS |=> res_valid && res_data == $past(in_a)); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid && $stable(res_data)); // R9

   AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op[2:1] == 2'b11 |=> !res_valid && $stable(res_data)); // R10

endmodule

bind alu_flag_exec alu_flag_exec_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/alu_flag_exec_test.sv
module alu_flag_exec_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    in_op = 3'd0;
   logic [W-1:0]  in_a = '0;
   logic [W-1:0]  in_b = '0;
   logic          in_flag_we = 1'b0;
   logic [W-1:0]  res_data;
   logic          res_valid;
   logic          cond_flag;

   int n_run = 0;
   int n_fail = 0;

   logic         m_flag = 1'b0;
   logic         m_vld = 1'b0;
   logic [W-1:0] m_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_flag_exec uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .in_flag_we(in_flag_we),
      .res_data(res_data), .res_valid(res_valid), .cond_flag(cond_flag)
   );

   task automatic compare(input string tag);
      n_run++;
      if (res_valid !== m_vld || res_data !== m_data || cond_flag !== m_flag) begin
         n_fail++;
         $display("FAIL %s: got valid=%0b data=%h flag=%0b, expected valid=%0b data=%h flag=%0b",
                  tag, res_valid, res_data, cond_flag, m_vld, m_data, m_flag);
      end
   endtask

   // Reference model: one operation, called at a falling edge; compares at the next one.
   task automatic step(input logic v, input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic we, input string tag);
      int s;
      logic nf;
      in_valid = v; in_op = op; in_a = a; in_b = b; in_flag_we = we;
      s  = (int'(a) + int'(b)) % 65536;
      nf = m_flag;
      m_vld = 1'b0;
      if (v) begin
         if (op == 3'd0 || op == 3'd1) begin
            m_vld = 1'b1; m_data = W'(s);
            if (op == 3'd0 && we) nf = (s == 0);
         end else if (op == 3'd2) begin
            if (we) nf = (a == b);
         end else if (op == 3'd3) begin
            m_vld = 1'b1; m_data = m_flag ? a : b;
         end else if (op == 3'd4) begin
            m_vld = 1'b1; m_data = m_flag ? 16'd1 : 16'd0;
         end else if (op == 3'd5) begin
            m_vld = 1'b1; m_data = a;
         end
      end
      m_flag = nf;
      @(negedge clk);
      compare(tag);
   endtask

   function automatic string tag_of(input logic v, input logic [2:0] op, input logic we);
      if (!v) return "R9";
      case (op)
         3'd0: return we ? "R2" : "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return "R10";
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");                       // during reset
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");                       // first cycle after release

      step(1, 3'd0, 16'h0001, 16'hFFFF, 1, "R2");  // wraps to zero, flag 1
      step(1, 3'd0, 16'h1234, 16'h0101, 0, "R3");  // flag kept at 1
      step(1, 3'd1, 16'h8000, 16'h8000, 1, "R4");  // zero sum, flag untouched
      step(1, 3'd1, 16'h0F00, 16'h00F0, 1, "R4");
      step(1, 3'd3, 16'hAAAA, 16'h5555, 0, "R6");  // flag 1 -> a
      step(1, 3'd2, 16'h0010, 16'h0011, 1, "R5");  // unequal -> flag 0
      step(1, 3'd3, 16'hAAAA, 16'h5555, 0, "R11"); // sees new flag -> b
      step(1, 3'd4, 16'h0000, 16'h0000, 0, "R7");  // -> 0
      step(1, 3'd2, 16'hBEEF, 16'hBEEF, 1, "R5");  // equal -> flag 1
      step(1, 3'd4, 16'h0000, 16'h0000, 0, "R11"); // -> 1 right after compare
      step(1, 3'd5, 16'h1234, 16'h0000, 1, "R8");  // pass, flag kept
      step(1, 3'd1, 16'h0002, 16'h0003, 1, "R4");
      step(1, 3'd4, 16'h0000, 16'h0000, 0, "R7");  // still 1 after intervening ops
      step(1, 3'd2, 16'h0001, 16'h0002, 0, "R5");  // we=0: no change
      step(0, 3'd0, 16'h0001, 16'hFFFF, 1, "R9");  // idle add with we
      step(1, 3'd6, 16'h0000, 16'h0001, 1, "R10");
      step(1, 3'd7, 16'h0005, 16'h0005, 1, "R10");
      step(1, 3'd0, 16'h7FFF, 16'h0001, 1, "R2");  // nonzero -> flag 0
      step(1, 3'd3, 16'h1111, 16'h2222, 0, "R11");
      step(1, 3'd0, 16'hFFFF, 16'hFFFF, 1, "R2");  // carry across all blocks

      for (int i = 0; i < 2000; i++) begin
         logic v, we;
         logic [2:0] op;
         logic [W-1:0] a, b;
         v  = ($urandom % 8) != 0;
         op = 3'($urandom % 8);
         we = 1'($urandom);
         a  = W'($urandom);
         b  = (($urandom % 4) == 0) ? a : W'($urandom);
         if (op == 3'd0 && ($urandom % 4) == 0) b = W'(0) - a;
         step(v, op, a, b, we, tag_of(v, op, we));
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule